// File: doc/BRIEF.md
# Crossbar Routing Control Register

This block holds the control word for a full audio crossbar. Four stereo input pairs can be sent to either of two stereo output pairs. A host writes bytes, each tagged with a subaddress. One subaddress loads the routing word. A second subaddress loads a general configuration byte, which also acts as the trigger for the deferred default. The routing word is decoded into one one-hot group of input enables per output. An all-zero group mutes that output.

The routing word behaves differently from the other configuration state when the chip loses power or enters standby. While the active-low standby input is low, the routing word and its decoded selects stay frozen, so the switches keep copying signals. Host writes are ignored during standby, and the configuration byte returns to its default. After a power-on reset or a standby exit, the routing default is held pending. It is applied by the first configuration-subaddress write, unless the host has already loaded the routing word directly, which cancels the pending default.

Top module: `route_matrix_ctrl`

## Requirements
- R1: After power-on reset (rstN low), every select line is 0 (all outputs muted) and cfgOut equals 0x00.
- R2: Routing field k sits at wrData bits [3k+2:3k]. Field value v in 0..3 raises only selOneHot[4k+v]. Any value with bit 2 set drives group k to all zero. Each group is one-hot or zero at all times.
- R3: A write to subaddress 0x12 loads wrData into cfgOut on the next clock edge.
- R4: If a write to subaddress 0x13 comes first after reset or standby exit, its value routes the outputs, and a later 0x12 write does not replace it with the default.
- R5: After the pending default is cleared, 0x12 writes leave routing unchanged, and 0x13 writes update it on the next edge.
- R6: While standbyN is low, the selects hold their value, writes to any subaddress are ignored, and cfgOut returns to 0x00.
- R7: After a standby exit, the held routing stays until the first 0x12 write. That write applies the default routing: output 0 from input 0 and output 1 from input 1 (selOneHot = 0x21).
- R8: Writes to subaddresses other than 0x12 and 0x13 change neither output.
- R9: Bits 7:6 of a routing write have no effect on the selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| standbyN | input | 1 | Active-low standby request |
| wrEn | input | 1 | Host write strobe, one cycle per byte |
| wrSub | input | 8 | Subaddress of the write |
| wrData | input | 8 | Data byte of the write |
| selOneHot | output | 8 | Input enables; bit 4k+i routes input i to output k |
| cfgOut | output | 8 | General configuration byte |

## Verification
The hardest case to reach is a routing word that has survived standby while the default is pending again. In that state the next 0x12 write must override a value that the host itself chose earlier. The stimulus first loads a non-default routing word and then cycles standbyN while issuing writes that must be ignored. It then follows the exit with both write orders: 0x12 first, and 0x13 first followed by 0x12. A mid-run power-on reset repeats the second order from the muted state.

// File: rtl/route_matrix_pkg.sv
package route_matrix_pkg;
  typedef struct packed {
    logic loadRoute;
    logic loadDefault;
    logic loadCfg;
    logic clearCfg;
  } strobe_t;
endpackage

// File: rtl/route_matrix_seq.sv
module route_matrix_seq
  import route_matrix_pkg::*;
#(
  parameter int SUB_W = 8,
  parameter logic [SUB_W-1:0] CFG_SUB = 8'h12,
  parameter logic [SUB_W-1:0] ROUTE_SUB = 8'h13
) (
  input  logic clk,
  input  logic rstN,
  input  logic standbyN,
  input  logic wrEn,
  input  logic [SUB_W-1:0] wrSub,
  output strobe_t strb
);
  logic defaultPending;
  logic hitCfg;
  logic hitRoute;

  assign hitCfg   = wrEn && standbyN && (wrSub == CFG_SUB);
  assign hitRoute = wrEn && standbyN && (wrSub == ROUTE_SUB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) defaultPending <= 1'b1;
    else if (!standbyN) defaultPending <= 1'b1;
    else if (hitCfg || hitRoute) defaultPending <= 1'b0;
  end

  always_comb begin
    strb.loadRoute   = hitRoute;
    strb.loadDefault = hitCfg && defaultPending && !hitRoute;
    strb.loadCfg     = hitCfg;
    strb.clearCfg    = !standbyN;
  end
endmodule

// File: rtl/route_matrix_path.sv
module route_matrix_path
  import route_matrix_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int NUM_OUT = 2,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ROUTE_DEFAULT = 8'h08,
  parameter logic [DATA_W-1:0] CFG_DEFAULT = 8'h00
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_OUT*NUM_IN-1:0] selOneHot,
  output logic [DATA_W-1:0] cfgOut
);
  localparam int IDX_W = $clog2(NUM_IN);
  localparam int SEL_W = IDX_W + 1;
  localparam int FIELD_W = SEL_W * NUM_OUT;

  logic [FIELD_W-1:0] routeReg;
  logic [FIELD_W-1:0] muteWord;

  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_mute
      assign muteWord[k*SEL_W +: SEL_W] = {1'b1, {IDX_W{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) routeReg <= muteWord;
    else if (strb.loadRoute) routeReg <= wrData[FIELD_W-1:0];
    else if (strb.loadDefault) routeReg <= ROUTE_DEFAULT[FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgOut <= CFG_DEFAULT;
    else if (strb.clearCfg) cfgOut <= CFG_DEFAULT;
    else if (strb.loadCfg) cfgOut <= wrData;
  end

  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      logic [SEL_W-1:0] field;
      assign field = routeReg[k*SEL_W +: SEL_W];
      for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        assign selOneHot[k*NUM_IN+i] = !field[SEL_W-1] && (field[IDX_W-1:0] == IDX_W'(i));
      end
    end
  endgenerate
endmodule

// File: rtl/route_matrix_ctrl.sv
module route_matrix_ctrl
  import route_matrix_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int NUM_OUT = 2,
  parameter int DATA_W = 8,
  parameter int SUB_W = 8,
  parameter logic [SUB_W-1:0] CFG_SUB = 8'h12,
  parameter logic [SUB_W-1:0] ROUTE_SUB = 8'h13,
  parameter logic [DATA_W-1:0] ROUTE_DEFAULT = 8'h08,
  parameter logic [DATA_W-1:0] CFG_DEFAULT = 8'h00
) (
  input  logic clk,
  input  logic rstN,
  input  logic standbyN,
  input  logic wrEn,
  input  logic [SUB_W-1:0] wrSub,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_OUT*NUM_IN-1:0] selOneHot,
  output logic [DATA_W-1:0] cfgOut
);
  strobe_t strb;

  route_matrix_seq #(
    .SUB_W(SUB_W), .CFG_SUB(CFG_SUB), .ROUTE_SUB(ROUTE_SUB)
  ) u_seq (
    .clk(clk), .rstN(rstN), .standbyN(standbyN), .wrEn(wrEn),
    .wrSub(wrSub), .strb(strb)
  );

  route_matrix_path #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W),
    .ROUTE_DEFAULT(ROUTE_DEFAULT), .CFG_DEFAULT(CFG_DEFAULT)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .selOneHot(selOneHot), .cfgOut(cfgOut)
  );
endmodule

// File: rtl/route_matrix_ctrl_chk.sv
module route_matrix_ctrl_chk #(
  parameter int NUM_IN = 4,
  parameter int NUM_OUT = 2,
  parameter int DATA_W = 8,
  parameter int SUB_W = 8,
  parameter logic [SUB_W-1:0] CFG_SUB = 8'h12,
  parameter logic [SUB_W-1:0] ROUTE_SUB = 8'h13,
  parameter logic [DATA_W-1:0] CFG_DEFAULT = 8'h00
) (
  input logic clk,
  input logic rstN,
  input logic standbyN,
  input logic wrEn,
  input logic [SUB_W-1:0] wrSub,
  input logic [DATA_W-1:0] wrData,
  input logic [NUM_OUT*NUM_IN-1:0] selOneHot,
  input logic [DATA_W-1:0] cfgOut
);
  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_grp
      // R2
      group_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(selOneHot[k*NUM_IN +: NUM_IN]));
    end
  endgenerate

  // R6
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !standbyN |=> $stable(selOneHot));

  // R6
  standby_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !standbyN |=> (cfgOut == CFG_DEFAULT));

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && standbyN && wrSub == CFG_SUB) |=> (cfgOut == $past(wrData)));

  // R8
  other_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && standbyN && wrSub != CFG_SUB && wrSub != ROUTE_SUB)
      |=> ($stable(selOneHot) && $stable(cfgOut)));
endmodule

bind route_matrix_ctrl route_matrix_ctrl_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W), .SUB_W(SUB_W),
  .CFG_SUB(CFG_SUB), .ROUTE_SUB(ROUTE_SUB), .CFG_DEFAULT(CFG_DEFAULT)
) u_chk (
  .clk(clk), .rstN(rstN), .standbyN(standbyN), .wrEn(wrEn), .wrSub(wrSub),
  .wrData(wrData), .selOneHot(selOneHot), .cfgOut(cfgOut)
);

// File: tb/sim_route_matrix_ctrl.sv
module sim_route_matrix_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standbyN = 1'b1;
  logic wrEn = 1'b0;
  logic [7:0] wrSub = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] selOneHot;
  logic [7:0] cfgOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mPending = 1'b1;
  int mRoute = 6'b100100;
  int mCfg = 0;

  route_matrix_ctrl u0 (
    .clk(clk), .rstN(rstN), .standbyN(standbyN), .wrEn(wrEn),
    .wrSub(wrSub), .wrData(wrData), .selOneHot(selOneHot), .cfgOut(cfgOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mPending = 1'b1; mRoute = 6'b100100; mCfg = 0;
    end else if (!standbyN) begin
      mPending = 1'b1; mCfg = 0;
    end else if (wrEn) begin
      if (wrSub == 8'h13) begin
        mRoute = int'(wrData) % 64; mPending = 1'b0;
      end else if (wrSub == 8'h12) begin
        mCfg = int'(wrData);
        if (mPending) mRoute = 8;
        mPending = 1'b0;
      end
    end
  end

  function automatic logic [7:0] expSel(int route);
    logic [7:0] e = 8'h00;
    for (int k = 0; k < 2; k++) begin
      int f = (route / (k == 0 ? 1 : 8)) % 8;
      if (f < 4) e[k*4 + f] = 1'b1;
    end
    return e;
  endfunction

  task automatic check(string req, logic [7:0] eSel, logic [7:0] eCfg);
    checks++;
    if (selOneHot !== eSel || cfgOut !== eCfg) begin
      errors++;
      $display("FAIL %s sel=%h cfg=%h expected sel=%h cfg=%h", req, selOneHot, cfgOut, eSel, eCfg);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check(curReq, expSel(mRoute), 8'(mCfg));
  endtask

  task automatic wr(logic [7:0] s, logic [7:0] d);
    wrEn = 1'b1; wrSub = s; wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    check("R1", 8'h00, 8'h00);
    curReq = "R8";
    wr(8'h40, 8'hFF);
    wr(8'h11, 8'h0B);
    check("R8", 8'h00, 8'h00);
    curReq = "R3";
    wr(8'h12, 8'h5A);
    check("R3", 8'h21, 8'h5A);
    curReq = "R5";
    wr(8'h13, 8'h1A);
    check("R5", 8'h84, 8'h5A);
    wr(8'h12, 8'h33);
    check("R5", 8'h84, 8'h33);
    curReq = "R2";
    for (int v = 0; v < 8; v++) begin
      wr(8'h13, 8'(v * 9));
      cyc();
    end
    wr(8'h13, 8'h24);
    check("R2", 8'h00, 8'h33);
    curReq = "R9";
    wr(8'h13, 8'hCB);
    check("R9", 8'h28, 8'h33);
    curReq = "R6";
    standbyN = 1'b0;
    cyc();
    wr(8'h13, 8'h00);
    wr(8'h12, 8'h77);
    cyc();
    check("R6", 8'h28, 8'h00);
    curReq = "R7";
    standbyN = 1'b1;
    cyc(); cyc();
    check("R7", 8'h28, 8'h00);
    wr(8'h12, 8'h11);
    check("R7", 8'h21, 8'h11);
    curReq = "R4";
    standbyN = 1'b0; cyc(); standbyN = 1'b1; cyc();
    wr(8'h13, 8'h09);
    check("R4", 8'h22, 8'h00);
    wr(8'h12, 8'h44);
    check("R4", 8'h22, 8'h44);
    curReq = "R1";
    rstN = 1'b0; cyc();
    check("R1", 8'h00, 8'h00);
    rstN = 1'b1; cyc();
    curReq = "R4";
    wr(8'h13, 8'h0A);
    wr(8'h12, 8'h01);
    check("R4", 8'h24, 8'h01);
    wr(8'h12, 8'h02);
    check("R5", 8'h24, 8'h02);
    repeat (4) cyc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule